// File: doc/BRIEF.md
# Segment Register Load Sequencer

This block runs the steps needed to put a new 16-bit selector into one of the data segment registers of a segmented address unit. A request names the destination register, supplies the selector, and says whether the machine is in real (or virtual-8086) mode and whether the destination is the stack segment. The sequencer then follows one of several paths. Some paths end by writing the register fields, and the others end by raising a fault. Each request ends with a one-cycle completion pulse that carries a fault code.

In protected mode the sequencer first hands the selector to an external selector-check unit. That unit returns the descriptor address, a null flag and a fault flag in the same cycle. For a non-null selector the sequencer makes one 8-byte read at that address through a flat port whose base is always zero. It passes the returned descriptor to an external decoder, then writes base, limit, attributes and selector in a single commit cycle. In real mode no table lookup happens: the selector is written, and the base is derived from the selector. The states are IDLE, CHECK, READ_WAIT, COMMIT and FAULT. The transitions are:
- IDLE→FAULT: bad destination register.
- IDLE→COMMIT: real mode.
- IDLE→CHECK: protected mode.
- CHECK→FAULT: check fault, or null selector with the stack flag set.
- CHECK→COMMIT: null selector with the stack flag clear.
- CHECK→READ_WAIT: non-null selector.
- READ_WAIT→COMMIT: read data returned.
- COMMIT→IDLE and FAULT→IDLE: always.

Top module: `seg_load_seq`

## Requirements
- R1: After reset, `done`, `wr_en` and `mem_rd` are 0 and `done_code` is 0.
- R2: A request with destination number 1 (code segment) writes nothing and issues no read. It ends as a fault with `done_code` = 1 (undefined opcode).
- R3: Destination numbers 6 and 7 are also refused, with `done_code` = 1, no write and no read. Numbers 0 and 2 to 5 are accepted.
- R4: In real mode the register is written one cycle after acceptance, with no check and no read. The selector and base are written, and base = zero-extended selector × 16. The limit and attribute enables stay 0.
- R5: In protected mode, when the check unit reports a null selector and the stack flag is 0, only the selector field is written. This happens two cycles after acceptance, and no read is issued.
- R6: A null selector with the stack flag set writes nothing and issues no read. It ends with `done_code` = 2 (general protection).
- R7: When the check unit reports a fault, the sequencer issues no read and writes nothing. It ends with `done_code` = 2.
- R8: A non-null selector causes exactly one read pulse, one cycle after acceptance, with `mem_addr` equal to the checked descriptor address.
- R9: After read data returns, the next cycle writes selector, base, limit and attributes together. Base, limit and attributes are taken from the decoder, whose input `dec_desc` holds the returned 64-bit word.
- R10: `done` pulses for exactly one cycle, in the cycle after the COMMIT or FAULT cycle. `done_code` is 0 for a completed load, 1 for undefined opcode and 2 for general protection.
- R11: A request presented while the sequencer is not idle is ignored. It causes no extra read, write or completion pulse, and it does not change the outcome of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only in IDLE |
| req_reg | input | 3 | Destination segment register number |
| req_sel | input | 16 | New selector value |
| req_real | input | 1 | 1 = real or virtual-8086 mode |
| req_stack | input | 1 | 1 = destination is the stack segment |
| chk_sel | output | 16 | Selector presented to the check unit |
| chk_addr | input | 32 | Descriptor address from the check unit |
| chk_null | input | 1 | Check unit: selector is null |
| chk_fault | input | 1 | Check unit: selector outside table |
| mem_rd | output | 1 | One-cycle 8-byte read strobe |
| mem_addr | output | 32 | Flat read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data (descriptor) |
| dec_desc | output | 64 | Descriptor word to the decoder |
| dec_base | input | 32 | Decoded base |
| dec_limit | input | 32 | Decoded limit |
| dec_attr | input | 16 | Decoded attributes |
| wr_en | output | 1 | Commit strobe |
| wr_reg | output | 3 | Register being written |
| wr_sel_en | output | 1 | Selector field write enable |
| wr_base_en | output | 1 | Base field write enable |
| wr_limit_en | output | 1 | Limit field write enable |
| wr_attr_en | output | 1 | Attribute field write enable |
| wr_sel | output | 16 | Selector value written |
| wr_base | output | 32 | Base value written |
| wr_limit | output | 32 | Limit value written |
| wr_attr | output | 16 | Attribute value written |
| done | output | 1 | Completion pulse |
| done_code | output | 2 | 0 none, 1 undefined opcode, 2 general protection |

## Verification
The bench builds the block with its default widths: 16-bit selector, 32-bit address, base and limit, 16-bit attributes and a 4-bit real-mode shift. Its memory responder returns data three cycles after the read strobe, so READ_WAIT is held across several idle cycles, and a stray early commit or a second read would show. With the 32-bit base, the top selector bits moved by the ×16 shift are visible at the port. Requests are also poked while the sequencer is busy, so that an accept outside IDLE would disturb the observed cycle pattern.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ_WAIT,
        ST_COMMIT,
        ST_FAULT
    } seq_state_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_GP   = 2'd2
    } flt_code_t;

    typedef enum logic [1:0] {
        CM_REAL,
        CM_SEL_ONLY,
        CM_FULL
    } commit_kind_t;

endpackage

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
    import seg_load_pkg::*;
#(
    parameter int REGW     = 3,
    parameter int CODE_REG = 1,
    parameter int LAST_REG = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [REGW-1:0] req_reg,
    input  logic            req_real,
    input  logic            req_stack,
    input  logic            chk_null,
    input  logic            chk_fault,
    input  logic            mem_rvalid,
    output logic            accept,
    output logic            capture,
    output logic            commit,
    output commit_kind_t    kind,
    output logic            mem_rd,
    output logic            done,
    output logic [1:0]      done_code
);

    seq_state_t   state, state_n;
    commit_kind_t kind_n;
    flt_code_t    fault_q, fault_n;
    logic         stack_q;
    logic         reg_bad;

    assign reg_bad = (req_reg == REGW'(CODE_REG)) || (req_reg > REGW'(LAST_REG));

    always_comb begin
        state_n = state;
        kind_n  = kind;
        fault_n = fault_q;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (reg_bad) begin
                        state_n = ST_FAULT;
                        fault_n = FLT_UD;
                    end else if (req_real) begin
                        state_n = ST_COMMIT;
                        kind_n  = CM_REAL;
                    end else begin
                        state_n = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (chk_fault || (chk_null && stack_q)) begin
                    state_n = ST_FAULT;
                    fault_n = FLT_GP;
                end else if (chk_null) begin
                    state_n = ST_COMMIT;
                    kind_n  = CM_SEL_ONLY;
                end else begin
                    state_n = ST_READ_WAIT;
                end
            end
            ST_READ_WAIT: begin
                if (mem_rvalid) begin
                    state_n = ST_COMMIT;
                    kind_n  = CM_FULL;
                end
            end
            ST_COMMIT: state_n = ST_IDLE;
            ST_FAULT:  state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= CM_REAL;
            fault_q   <= FLT_NONE;
            stack_q   <= 1'b0;
            done      <= 1'b0;
            done_code <= 2'd0;
        end else begin
            state     <= state_n;
            kind      <= kind_n;
            fault_q   <= fault_n;
            if (accept) stack_q <= req_stack;
            done      <= (state == ST_COMMIT) || (state == ST_FAULT);
            done_code <= (state == ST_FAULT) ? fault_q : FLT_NONE;
        end
    end

    always_comb begin
        accept  = (state == ST_IDLE) && req_valid;
        mem_rd  = (state == ST_CHECK) && !chk_fault && !chk_null;
        capture = (state == ST_READ_WAIT) && mem_rvalid;
        commit  = (state == ST_COMMIT);
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    a_r6_null_stack_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && chk_null && stack_q) |=> (state == ST_FAULT));
    a_r2_code_reg_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && req_reg == REGW'(CODE_REG)) |=> (state == ST_FAULT));
    a_r10_commit_clean: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (done && done_code == 2'd0));
    a_r11_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_WAIT) |=> (state != ST_CHECK));

endmodule

// File: rtl/seg_load_commit.sv
module seg_load_commit
    import seg_load_pkg::*;
#(
    parameter int REGW  = 3,
    parameter int SELW  = 16,
    parameter int BW    = 32,
    parameter int LW    = 32,
    parameter int ATW   = 16,
    parameter int DW    = 64,
    parameter int SHIFT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [REGW-1:0] req_reg,
    input  logic [SELW-1:0] req_sel,
    input  logic            capture,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            commit,
    input  commit_kind_t    kind,
    input  logic [BW-1:0]   dec_base,
    input  logic [LW-1:0]   dec_limit,
    input  logic [ATW-1:0]  dec_attr,
    output logic [SELW-1:0] sel_q,
    output logic [DW-1:0]   desc_q,
    output logic            wr_en,
    output logic [REGW-1:0] wr_reg,
    output logic            wr_sel_en,
    output logic            wr_base_en,
    output logic            wr_limit_en,
    output logic            wr_attr_en,
    output logic [SELW-1:0] wr_sel,
    output logic [BW-1:0]   wr_base,
    output logic [LW-1:0]   wr_limit,
    output logic [ATW-1:0]  wr_attr
);

    localparam int PADW = BW - SELW;

    logic [REGW-1:0] reg_q;
    logic [BW-1:0]   real_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            reg_q  <= '0;
            desc_q <= '0;
        end else begin
            if (accept) begin
                sel_q <= req_sel;
                reg_q <= req_reg;
            end
            if (capture) desc_q <= mem_rdata;
        end
    end

    assign real_base = {{PADW{1'b0}}, sel_q} << SHIFT;

    always_comb begin
        wr_en       = commit;
        wr_reg      = reg_q;
        wr_sel_en   = commit;
        wr_base_en  = commit && (kind != CM_SEL_ONLY);
        wr_limit_en = commit && (kind == CM_FULL);
        wr_attr_en  = commit && (kind == CM_FULL);
        wr_sel      = sel_q;
        wr_base     = (kind == CM_REAL) ? real_base : dec_base;
        wr_limit    = dec_limit;
        wr_attr     = dec_attr;
    end

    a_r11_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(sel_q));
    a_r9_desc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !accept) |=> $stable(desc_q));

endmodule

// File: rtl/seg_load_seq.sv
module seg_load_seq
    import seg_load_pkg::*;
#(
    parameter int REGW  = 3,
    parameter int SELW  = 16,
    parameter int AW    = 32,
    parameter int BW    = 32,
    parameter int LW    = 32,
    parameter int ATW   = 16,
    parameter int DW    = 64,
    parameter int SHIFT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [REGW-1:0] req_reg,
    input  logic [SELW-1:0] req_sel,
    input  logic            req_real,
    input  logic            req_stack,
    output logic [SELW-1:0] chk_sel,
    input  logic [AW-1:0]   chk_addr,
    input  logic            chk_null,
    input  logic            chk_fault,
    output logic            mem_rd,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   dec_desc,
    input  logic [BW-1:0]   dec_base,
    input  logic [LW-1:0]   dec_limit,
    input  logic [ATW-1:0]  dec_attr,
    output logic            wr_en,
    output logic [REGW-1:0] wr_reg,
    output logic            wr_sel_en,
    output logic            wr_base_en,
    output logic            wr_limit_en,
    output logic            wr_attr_en,
    output logic [SELW-1:0] wr_sel,
    output logic [BW-1:0]   wr_base,
    output logic [LW-1:0]   wr_limit,
    output logic [ATW-1:0]  wr_attr,
    output logic            done,
    output logic [1:0]      done_code
);

    logic         accept, capture, commit;
    commit_kind_t kind;

    seg_load_ctrl #(.REGW(REGW)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_reg(req_reg),
        .req_real(req_real), .req_stack(req_stack),
        .chk_null(chk_null), .chk_fault(chk_fault),
        .mem_rvalid(mem_rvalid),
        .accept(accept), .capture(capture), .commit(commit), .kind(kind),
        .mem_rd(mem_rd), .done(done), .done_code(done_code)
    );

    seg_load_commit #(
        .REGW(REGW), .SELW(SELW), .BW(BW), .LW(LW),
        .ATW(ATW), .DW(DW), .SHIFT(SHIFT)
    ) i_commit (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .req_reg(req_reg), .req_sel(req_sel),
        .capture(capture), .mem_rdata(mem_rdata),
        .commit(commit), .kind(kind),
        .dec_base(dec_base), .dec_limit(dec_limit), .dec_attr(dec_attr),
        .sel_q(chk_sel), .desc_q(dec_desc),
        .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_sel_en(wr_sel_en), .wr_base_en(wr_base_en),
        .wr_limit_en(wr_limit_en), .wr_attr_en(wr_attr_en),
        .wr_sel(wr_sel), .wr_base(wr_base), .wr_limit(wr_limit), .wr_attr(wr_attr)
    );

    assign mem_addr = chk_addr;

    a_r8_read_has_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !wr_en);

endmodule

// File: tb/test_seg_load_seq.sv
module test_seg_load_seq;

    localparam int LAT = 3;
    localparam logic [31:0] TBL = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_reg = '0;
    logic [15:0] req_sel = '0;
    logic        req_real = 1'b0, req_stack = 1'b0;
    logic [15:0] chk_sel;
    logic [31:0] chk_addr;
    logic        chk_null, chk_fault;
    logic        inj_fault = 1'b0;
    logic        mem_rd, mem_rvalid = 1'b0;
    logic [31:0] mem_addr;
    logic [63:0] mem_rdata = '0, dec_desc;
    logic [31:0] dec_base, dec_limit;
    logic [15:0] dec_attr;
    logic        wr_en, wr_sel_en, wr_base_en, wr_limit_en, wr_attr_en;
    logic [2:0]  wr_reg;
    logic [15:0] wr_sel, wr_attr;
    logic [31:0] wr_base, wr_limit;
    logic        done;
    logic [1:0]  done_code;

    int checks = 0;
    int errors = 0;
    int pend = 0;
    logic [31:0] rd_addr_seen = '0;

    always #4 clk = ~clk;

    seg_load_seq i_seg_load_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_reg(req_reg), .req_sel(req_sel),
        .req_real(req_real), .req_stack(req_stack),
        .chk_sel(chk_sel), .chk_addr(chk_addr), .chk_null(chk_null), .chk_fault(chk_fault),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .dec_desc(dec_desc), .dec_base(dec_base), .dec_limit(dec_limit), .dec_attr(dec_attr),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_sel_en(wr_sel_en), .wr_base_en(wr_base_en),
        .wr_limit_en(wr_limit_en), .wr_attr_en(wr_attr_en),
        .wr_sel(wr_sel), .wr_base(wr_base), .wr_limit(wr_limit), .wr_attr(wr_attr),
        .done(done), .done_code(done_code)
    );

    // external units modelled behaviourally
    assign chk_null  = (chk_sel[15:2] == 14'd0);
    assign chk_addr  = TBL + {16'd0, chk_sel[15:3], 3'b000};
    assign chk_fault = inj_fault;
    assign dec_base  = dec_desc[31:0];
    assign dec_limit = dec_desc[63:32];
    assign dec_attr  = dec_desc[15:0] ^ 16'h0F0F;

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        return {a ^ 32'hA5A5_0000, ~a};
    endfunction

    always @(negedge clk) begin
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_word(rd_addr_seen);
            end
        end else begin
            mem_rvalid = 1'b0;
        end
        if (mem_rd) begin
            pend = LAT;
            rd_addr_seen = mem_addr;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // kind: 0 undefined-op, 1 real, 2 null sel-only, 3 gp, 4 full
    task automatic run_case(input string req, input logic [2:0] r, input logic [15:0] s,
                            input logic rm, input logic st, input logic flt,
                            input int kind, input logic poke);
        int rd_c, wr_c, dn_c, code;
        logic [31:0] daddr;
        logic [63:0] dw;
        daddr = TBL + {16'd0, s[15:3], 3'b000};
        dw    = mem_word(daddr);
        rd_c = -1; wr_c = -1; code = 0;
        case (kind)
            0: begin dn_c = 2; code = 1; end
            1: begin wr_c = 1; dn_c = 2; end
            2: begin wr_c = 2; dn_c = 3; end
            3: begin dn_c = 3; code = 2; end
            default: begin rd_c = 1; wr_c = 2 + LAT; dn_c = 3 + LAT; end
        endcase
        @(negedge clk);
        req_valid = 1'b1; req_reg = r; req_sel = s; req_real = rm; req_stack = st;
        inj_fault = flt;
        for (int c = 1; c <= dn_c + 2; c++) begin
            @(negedge clk);
            #1;
            req_valid = poke && (c <= dn_c - 1);
            req_reg = 3'd4; req_sel = 16'h7FF8; req_real = 1'b0; req_stack = 1'b1;
            chk(req, $sformatf("mem_rd c%0d", c), mem_rd, (c == rd_c));
            chk(req, $sformatf("wr_en c%0d", c), wr_en, (c == wr_c));
            chk(req, $sformatf("done c%0d", c), done, (c == dn_c));
            if (c == rd_c) chk(req, "mem_addr", mem_addr, daddr);
            if (c == wr_c) begin
                chk(req, "wr_reg", wr_reg, r);
                chk(req, "wr_sel", wr_sel, s);
                chk(req, "wr_sel_en", wr_sel_en, 1);
                chk(req, "wr_base_en", wr_base_en, (kind != 2));
                chk(req, "wr_limit_en", wr_limit_en, (kind == 4));
                chk(req, "wr_attr_en", wr_attr_en, (kind == 4));
                if (kind == 1) chk(req, "wr_base real", wr_base, {16'd0, s} * 32'd16);
                if (kind == 4) begin
                    chk(req, "dec_desc", dec_desc, dw);
                    chk(req, "wr_base", wr_base, dw[31:0]);
                    chk(req, "wr_limit", wr_limit, dw[63:32]);
                    chk(req, "wr_attr", wr_attr, dw[15:0] ^ 16'h0F0F);
                end
            end
            if (c == dn_c) chk(req, "done_code", done_code, code);
        end
        req_valid = 1'b0; inj_fault = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done", done, 0);
        chk("R1", "wr_en", wr_en, 0);
        chk("R1", "mem_rd", mem_rd, 0);
        chk("R1", "done_code", done_code, 0);

        run_case("R2", 3'd1, 16'h0010, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        run_case("R2", 3'd1, 16'h0013, 1'b1, 1'b0, 1'b0, 0, 1'b0);
        run_case("R3", 3'd6, 16'h0020, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        run_case("R3", 3'd7, 16'h0020, 1'b1, 1'b0, 1'b0, 0, 1'b0);
        run_case("R4", 3'd3, 16'hF123, 1'b1, 1'b0, 1'b0, 1, 1'b0);
        run_case("R4", 3'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 1, 1'b0);
        run_case("R5", 3'd5, 16'h0003, 1'b0, 1'b0, 1'b0, 2, 1'b0);
        run_case("R6", 3'd2, 16'h0001, 1'b0, 1'b1, 1'b0, 3, 1'b0);
        run_case("R7", 3'd4, 16'h0F28, 1'b0, 1'b0, 1'b1, 3, 1'b0);
        run_case("R8", 3'd3, 16'h0028, 1'b0, 1'b0, 1'b0, 4, 1'b0);
        run_case("R9", 3'd2, 16'hFFFB, 1'b0, 1'b1, 1'b0, 4, 1'b0);
        run_case("R10", 3'd0, 16'h1234, 1'b0, 1'b0, 1'b0, 4, 1'b0);
        run_case("R11", 3'd5, 16'h0040, 1'b0, 1'b0, 1'b0, 4, 1'b1);
        run_case("R11", 3'd3, 16'h0002, 1'b0, 1'b0, 1'b0, 2, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule